// File: doc/BRIEF.md
# Sequential single-precision floating-point multiplier

This block multiplies two 32-bit binary floating-point numbers over several clock cycles. A caller presents both operands with a one-cycle `start` strobe while the unit is idle. The unit then raises `busy`. It runs an iterative shift-and-add product of the two 24-bit significands, a few multiplier bits per cycle. When it finishes, it drops `busy` and pulses `done` for one cycle. The packed result and two exception flags are presented with `done` and held until the next result.

Each operand is unpacked first. Subnormal inputs are renormalised so that every finite nonzero operand reaches the multiplier with a leading one. The biased exponents are added and one bias is removed. A product of 2 or more is shifted right once and its exponent is incremented. The value is then rounded to nearest with ties to even. Results too small for the normal range are denormalised before rounding, so that only one rounding takes place. The sign is the exclusive-or of the operand signs and is applied last. Zero, infinity and NaN operands bypass the arithmetic through a separate special-value path, but they keep the same latency.

Top module: `fp32_mul_seq`

## Requirements
- R1: For normal operands whose exact product is representable, `result` equals the exact product. Its exponent field is the sum of the operand exponent fields minus 127.
- R2: When the significand product is 2 or more, the result significand is shifted right once and the exponent field is one higher. For example, 1.5 × 1.5 gives 0x40100000.
- R3: Inexact products round to nearest, ties to even. Guard, round and sticky information is taken from the discarded product bits.
- R4: Bit 31 of every non-NaN result is the exclusive-or of bit 31 of the two operands.
- R5: If the rounded exponent field would reach 255, `result` is infinity (exponent field 0xFF, fraction 0) with the operand sign, and `ovf` is 1. `ovf` and `unf` are never both 1.
- R6: If the normalised exponent field is below 1, the value is shifted into subnormal form and rounded once, and `unf` is 1. The result may be a subnormal, zero, or the smallest normal (0x00800000) when rounding carries up.
- R7: Subnormal operands (exponent field 0, fraction nonzero) are treated by their exact value, 0.fraction × 2^-126.
- R8: Any NaN operand (exponent field 0xFF, fraction nonzero), and zero times infinity, give exactly 0x7FC00000 with both flags 0.
- R9: Infinity times a finite nonzero value gives infinity with the exclusive-or sign. Zero times a finite value gives zero with the exclusive-or sign. Both flags are 0 in these cases.
- R10: A `start` sampled while `busy` is 0 is accepted. `done` then pulses for exactly one cycle, MUL_CYCLES+1 clock edges after the accepting edge. `busy` is 1 in between. A `start` while `busy` is 1 is ignored. `result` changes only in the cycle `done` is 1.
- R11: While `rst_n` is 0 at a clock edge, `busy`, `done`, `ovf` and `unf` become 0 and `result` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Operation request, accepted when not busy |
| op_a | input | 32 | First operand, single-precision bit pattern |
| op_b | input | 32 | Second operand, single-precision bit pattern |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Packed product, held between operations |
| ovf | output | 1 | Result overflowed to infinity |
| unf | output | 1 | Normalised exponent fell below the normal range |

## Verification
The scoreboard issues exact normal products to confirm the exponent sum and the bias removal. It also issues a product at or above two, which tells a missing normalising shift apart from a correct one. Rounding is probed with three operand pairs that give a value below half an ulp, a tie on an odd significand and a tie on an even significand. These three cases separate round-to-nearest-even from truncation and from round-half-up. Overflow and gradual underflow are covered, including a subnormal tie that carries into the smallest normal. A subnormal operand scaled back into range shows whether the leading-zero renormalisation is correct. The special-value path is exercised with NaN, zero times infinity, and signed infinity and zero cases. A `start` pulse injected during every operation must produce no extra result.

// File: rtl/fpm_pkg.sv
// Shared widths, derived sizes and the unpacked-operand record used by the
// single-precision multiplier. Assumes an IEEE-style binary format with a
// hidden leading one and a bias of 2^(EXP_W-1)-1.
package fpm_pkg;
    parameter int EXP_W    = 8;
    parameter int FRAC_W   = 23;
    parameter int MUL_STEP = 4;

    localparam int SIG_W      = FRAC_W + 1;
    localparam int WORD_W     = 1 + EXP_W + FRAC_W;
    localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
    localparam int XEXP_W     = EXP_W + 3;
    localparam int PROD_W     = 2 * SIG_W;
    localparam int MUL_CYCLES = (SIG_W + MUL_STEP - 1) / MUL_STEP;
    localparam int EMAX_FIELD = (1 << EXP_W) - 1;

    // Canonical quiet NaN without its sign bit.
    localparam logic [WORD_W-2:0] QNAN_MAG = {{EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic              inf;
        logic              nan;
        logic [XEXP_W-1:0] exp;   // two's complement biased exponent
        logic [SIG_W-1:0]  sig;   // leading one at SIG_W-1 for finite nonzero
    } fpm_opnd_t;
endpackage

// File: rtl/fpm_unpack.sv
// Splits one packed operand into class flags, a signed biased exponent and a
// significand with its leading one in the top bit. Subnormals are shifted
// left by their leading-zero count and their exponent lowered to match.
// Assumes nothing about the operand; purely combinational.
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    output fpm_opnd_t         opnd
);
    localparam int LZ_W = $clog2(SIG_W + 1);

    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    logic [SIG_W-1:0]  sub_mant;
    logic [LZ_W-1:0]   lz;
    logic              seen;

    assign efield   = raw[WORD_W-2 -: EXP_W];
    assign ffield   = raw[FRAC_W-1:0];
    assign sub_mant = {1'b0, ffield};

    // Count leading zeros of the subnormal significand.
    always_comb begin
        lz   = '0;
        seen = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (sub_mant[i]) seen = 1'b1;
                else             lz   = lz + LZ_W'(1);
            end
        end
    end

    // Classify the operand and produce its normalised fields.
    always_comb begin
        opnd.sign = raw[WORD_W-1];
        opnd.nan  = (&efield) && (|ffield);
        opnd.inf  = (&efield) && !(|ffield);
        opnd.zero = (efield == '0) && (ffield == '0);
        if (efield == '0) begin
            opnd.sig = sub_mant << lz;
            opnd.exp = XEXP_W'(1) - XEXP_W'(lz);
        end else begin
            opnd.sig = {1'b1, ffield};
            opnd.exp = XEXP_W'(efield);
        end
    end
endmodule

// File: rtl/fpm_sigmul.sv
// Iterative unsigned shift-and-add multiplier. Consumes STEP multiplier bits
// per cycle and raises prod_vld for one cycle after CYC steps. A load while
// running restarts it. Assumes the caller holds no expectation on prod
// before prod_vld.
module fpm_sigmul #(
    parameter int W    = 24,
    parameter int STEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] prod,
    output logic           prod_vld
);
    localparam int PW   = 2 * W;
    localparam int CYC  = (W + STEP - 1) / STEP;
    localparam int CW   = $clog2(CYC + 1);

    logic [PW-1:0] acc, mc_sh, pp_sum;
    logic [W-1:0]  mp_sh;
    logic [CW-1:0] left;
    logic          run;

    // Partial products for the STEP low multiplier bits of this cycle.
    logic [PW-1:0] pp_row [STEP];
    for (genvar j = 0; j < STEP; j++) begin : g_row
        assign pp_row[j] = mp_sh[j] ? (mc_sh << j) : '0;
    end

    // Sum the partial-product rows.
    always_comb begin
        pp_sum = '0;
        for (int j = 0; j < STEP; j++) pp_sum = pp_sum + pp_row[j];
    end

    // Step the accumulation and signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            mc_sh    <= '0;
            mp_sh    <= '0;
            left     <= '0;
            run      <= 1'b0;
            prod_vld <= 1'b0;
        end else begin
            prod_vld <= 1'b0;
            if (load) begin
                acc   <= '0;
                mc_sh <= PW'(mcand);
                mp_sh <= mplier;
                left  <= CW'(CYC);
                run   <= 1'b1;
            end else if (run) begin
                acc   <= acc + pp_sum;
                mc_sh <= mc_sh << STEP;
                mp_sh <= mp_sh >> STEP;
                left  <= left - CW'(1);
                if (left == CW'(1)) begin
                    run      <= 1'b0;
                    prod_vld <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;
endmodule

// File: rtl/fpm_normround.sv
// Normalises a significand product in [1,4), denormalises it when the
// exponent is below the normal range, rounds once to nearest-even and packs
// the word. Assumes both operands were finite and nonzero (prod top two bits
// not both zero). Sign is attached here as the final step.
module fpm_normround
    import fpm_pkg::*;
(
    input  logic              sign,
    input  logic [XEXP_W-1:0] exp_sum,
    input  logic [PROD_W-1:0] prod,
    output logic [WORD_W-1:0] word,
    output logic              ovf,
    output logic              unf
);
    localparam int XW = SIG_W + 3;
    localparam logic signed [XEXP_W-1:0] ONE_S  = XEXP_W'(1);
    localparam logic signed [XEXP_W-1:0] EMAX_S = XEXP_W'(EMAX_FIELD);

    logic                     hi;
    logic [SIG_W-1:0]         mant;
    logic                     g_bit, r_bit, s_bit;
    logic signed [XEXP_W-1:0] e_norm, e_fin;
    logic [XEXP_W-1:0]        shift_amt;
    logic                     denorm;
    logic [XW-1:0]            xv, yv;
    logic                     lost;
    int                       sh_i;
    logic [SIG_W-1:0]         kept;
    logic                     up;
    logic [SIG_W:0]           kr;

    // Single normalising shift when the product reached two.
    always_comb begin
        hi = prod[PROD_W-1];
        if (hi) begin
            mant  = prod[PROD_W-1 -: SIG_W];
            g_bit = prod[PROD_W-1-SIG_W];
            r_bit = prod[PROD_W-2-SIG_W];
            s_bit = |prod[PROD_W-3-SIG_W:0];
        end else begin
            mant  = prod[PROD_W-2 -: SIG_W];
            g_bit = prod[PROD_W-2-SIG_W];
            r_bit = prod[PROD_W-3-SIG_W];
            s_bit = |prod[PROD_W-4-SIG_W:0];
        end
        e_norm = $signed(exp_sum) + $signed(XEXP_W'(hi));
    end

    // Right shift into subnormal form, folding lost bits into sticky.
    always_comb begin
        denorm    = e_norm < ONE_S;
        shift_amt = XEXP_W'(ONE_S - e_norm);
        if (!denorm)                   sh_i = 0;
        else if (shift_amt > XEXP_W'(XW)) sh_i = XW;
        else                           sh_i = int'(shift_amt);
        xv   = {mant, g_bit, r_bit, s_bit};
        lost = 1'b0;
        for (int i = 0; i < XW; i++) begin
            if (i < sh_i) lost = lost | xv[i];
        end
        yv    = xv >> sh_i;
        yv[0] = yv[0] | lost;
    end

    // Round to nearest, ties to even.
    always_comb begin
        kept = yv[XW-1:3];
        up   = yv[2] & (yv[1] | yv[0] | kept[0]);
        kr   = {1'b0, kept} + (SIG_W+1)'(up);
    end

    // Range checks and packing; the sign goes on last.
    always_comb begin
        e_fin = e_norm + $signed(XEXP_W'(kr[SIG_W]));
        ovf   = 1'b0;
        unf   = 1'b0;
        if (denorm) begin
            unf  = 1'b1;
            word = {sign, EXP_W'(kr[SIG_W-1]), kr[FRAC_W-1:0]};
        end else if (e_fin >= EMAX_S) begin
            ovf  = 1'b1;
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word = {sign, e_fin[EXP_W-1:0], kr[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpm_special.sv
// Decides whether the product is fixed by operand classes alone (NaN,
// infinity, zero) and builds that word. Assumes the operands come from
// fpm_unpack. NaN outputs are always the canonical quiet NaN.
module fpm_special
    import fpm_pkg::*;
(
    input  fpm_opnd_t         opa,
    input  fpm_opnd_t         opb,
    input  logic              sign,
    output logic              hit,
    output logic [WORD_W-1:0] word
);
    logic make_nan, make_inf, make_zero;

    // Priority: NaN, then infinity, then zero.
    always_comb begin
        make_nan  = opa.nan || opb.nan || (opa.zero && opb.inf) || (opa.inf && opb.zero);
        make_inf  = !make_nan && (opa.inf || opb.inf);
        make_zero = !make_nan && !make_inf && (opa.zero || opb.zero);
        hit       = make_nan || make_inf || make_zero;
        if (make_nan)      word = {1'b0, QNAN_MAG};
        else if (make_inf) word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else               word = {sign, {(WORD_W-1){1'b0}}};
    end
endmodule

// File: rtl/fp32_mul_seq.sv
// Sequential single-precision multiplier top. Accepts a start while idle,
// registers the unpacked operands, runs the iterative significand product,
// then registers the packed result with a one-cycle done. Assumes start is
// synchronous to clk; starts while busy are dropped.
module fp32_mul_seq
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf
);
    localparam logic [XEXP_W-1:0] BIAS_X = XEXP_W'(BIAS);

    typedef enum logic {ST_IDLE, ST_MUL} state_t;

    state_t            state;
    fpm_opnd_t         ua, ub, opa_q, opb_q;
    logic              accept;
    logic [PROD_W-1:0] prod;
    logic              prod_vld;
    logic              res_sign;
    logic [XEXP_W-1:0] exp_sum;
    logic [WORD_W-1:0] arith_word, spec_word;
    logic              arith_ovf, arith_unf, spec_hit;
    logic              done_q, ovf_q, unf_q;
    logic [WORD_W-1:0] result_q;

    fpm_unpack u_unpack_a (.raw(op_a), .opnd(ua));
    fpm_unpack u_unpack_b (.raw(op_b), .opnd(ub));

    assign accept = start && (state == ST_IDLE);

    fpm_sigmul #(.W(SIG_W), .STEP(MUL_STEP)) u_sigmul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .mcand    (ua.sig),
        .mplier   (ub.sig),
        .prod     (prod),
        .prod_vld (prod_vld)
    );

    // Biased exponent sum with one bias removed; sign kept apart.
    assign exp_sum  = opa_q.exp + opb_q.exp - BIAS_X;
    assign res_sign = opa_q.sign ^ opb_q.sign;

    fpm_normround u_normround (
        .sign    (res_sign),
        .exp_sum (exp_sum),
        .prod    (prod),
        .word    (arith_word),
        .ovf     (arith_ovf),
        .unf     (arith_unf)
    );

    fpm_special u_special (
        .opa  (opa_q),
        .opb  (opb_q),
        .sign (res_sign),
        .hit  (spec_hit),
        .word (spec_word)
    );

    // Control sequence and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (accept) begin
                state <= ST_MUL;
                opa_q <= ua;
                opb_q <= ub;
            end else if (state == ST_MUL && prod_vld) begin
                state <= ST_IDLE;
            end
        end
    end

    // Result register, flags and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == ST_MUL && prod_vld) begin
                done_q   <= 1'b1;
                result_q <= spec_hit ? spec_word : arith_word;
                ovf_q    <= spec_hit ? 1'b0 : arith_ovf;
                unf_q    <= spec_hit ? 1'b0 : arith_unf;
            end
        end
    end

    assign busy   = (state == ST_MUL);
    assign done   = done_q;
    assign result = result_q;
    assign ovf    = ovf_q;
    assign unf    = unf_q;
endmodule

// File: rtl/fp32_mul_seq_chk.sv
// Protocol and result-shape checks for fp32_mul_seq, attached by bind.
// Assumes the package defaults for widths and multiplier step.
module fp32_mul_seq_chk
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              ovf,
    input logic              unf
);
    localparam int LAT = MUL_CYCLES + 1;
    localparam int LCW = $clog2(LAT + 2);

    logic [LCW-1:0] since;
    logic           sgn_q;
    logic           res_nan;

    assign res_nan = (&result[WORD_W-2 -: EXP_W]) && (|result[FRAC_W-1:0]);

    // Count edges since the last accepted start and keep its expected sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            sgn_q <= 1'b0;
        end else if (start && !busy) begin
            since <= '0;
            sgn_q <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
        end else if (since != LCW'(LAT + 1)) begin
            since <= since + LCW'(1);
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R10
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since == LCW'(LAT))); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R10
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_nan) |-> (result[WORD_W-1] == sgn_q)); // R4
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_nan) |-> (result == {1'b0, QNAN_MAG} && !ovf && !unf)); // R8
    AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ovf && unf)); // R5
    AST_UNF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unf) |-> (result[WORD_W-2 -: EXP_W] <= EXP_W'(1))); // R6
endmodule

bind fp32_mul_seq fp32_mul_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .busy   (busy),
    .done   (done),
    .result (result),
    .ovf    (ovf),
    .unf    (unf)
);

// File: tb/tb_fp32_mul_seq.sv
// Scoreboard bench: the driver queues expected results, the monitor pops and
// compares them as done pulses arrive.
module tb_fp32_mul_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_TO_DONE = (24 + 4 - 1) / 4 + 2;  // drive negedge to done negedge

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_w;
        logic        exp_o;
        logic        exp_u;
        string       req;
        int          issued;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done, ovf, unf;
    logic [31:0] result;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    n_issued = 0;
    int    n_done = 0;
    bit    finished = 1'b0;

    fp32_mul_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result), .ovf(ovf), .unf(unf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Driver: queue the expectation, pulse start, then poke a start while busy.
    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] w, input logic o, input logic u,
                         input string req);
        item_t it;
        while (busy) @(negedge clk);
        it.a = a; it.b = b; it.exp_w = w; it.exp_o = o; it.exp_u = u;
        it.req = req; it.issued = cyc;
        sb.push_back(it);
        n_issued++;
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = 32'h40400000; op_b = 32'h40400000; start = 1'b1;  // R10: must be ignored
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare each completion against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 64'(result), 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(result == it.exp_w && ovf == it.exp_o && unf == it.exp_u, it.req,
                      $sformatf("a=%h b=%h {result,ovf,unf}", it.a, it.b),
                      {30'h0, result, ovf, unf}, {30'h0, it.exp_w, it.exp_o, it.exp_u});
                check(cyc - it.issued == CYC_TO_DONE, "R10", "latency",
                      64'(cyc - it.issued), 64'(CYC_TO_DONE));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !done && !ovf && !unf && result == 32'h0, "R11", "reset outputs",
              {27'h0, busy, done, ovf, unf, result, 1'b0}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(32'h3F000000, 32'hBEE00000, 32'hBE600000, 1'b0, 1'b0, "R1");  // 0.5*-0.4375
        issue(32'h40F00000, 32'h3F800000, 32'h40F00000, 1'b0, 1'b0, "R1");  // 7.5*1
        issue(32'h40000000, 32'h40000000, 32'h40800000, 1'b0, 1'b0, "R2");  // 2*2
        issue(32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, "R2");  // 1.5*1.5
        issue(32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0, 1'b0, "R3");  // below half
        issue(32'h3FC00000, 32'h3F800001, 32'h3FC00002, 1'b0, 1'b0, "R3");  // tie, odd -> up
        issue(32'h3FC00000, 32'h3F800003, 32'h3FC00004, 1'b0, 1'b0, "R3");  // tie, even -> stay
        issue(32'h3FE00000, 32'h3F800001, 32'h3FE00002, 1'b0, 1'b0, "R3");  // above half
        issue(32'hBFC00000, 32'hBFC00000, 32'h40100000, 1'b0, 1'b0, "R4");  // neg*neg
        issue(32'hC0F00000, 32'h3F800000, 32'hC0F00000, 1'b0, 1'b0, "R4");  // neg*pos
        issue(32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, "R5");  // 2^127*2
        issue(32'hFF000000, 32'h7F000000, 32'hFF800000, 1'b1, 1'b0, "R5");  // signed overflow
        issue(32'h00800000, 32'h3F000000, 32'h00400000, 1'b0, 1'b1, "R6");  // to subnormal
        issue(32'h00800000, 32'h00800000, 32'h00000000, 1'b0, 1'b1, "R6");  // to zero
        issue(32'h00FFFFFF, 32'h3F000000, 32'h00800000, 1'b0, 1'b1, "R6");  // carry to min normal
        issue(32'h00000001, 32'h4B000000, 32'h00800000, 1'b0, 1'b0, "R7");  // subnormal operand
        issue(32'h00000001, 32'h00000001, 32'h00000000, 1'b0, 1'b1, "R7");  // two subnormals
        issue(32'h7FC00001, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, "R8");  // NaN in
        issue(32'h00000000, 32'hFF800000, 32'h7FC00000, 1'b0, 1'b0, "R8");  // 0*inf
        issue(32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 1'b0, "R9");  // inf*-2
        issue(32'h80000000, 32'h40A00000, 32'h80000000, 1'b0, 1'b0, "R9");  // -0*5
        issue(32'h80000000, 32'hC0400000, 32'h00000000, 1'b0, 1'b0, "R9");  // -0*-3

        while (busy || sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        // R10: one completion per accepted start, none from starts while busy
        check(n_done == n_issued && sb.size() == 0, "R10", "completion count",
              64'(n_done), 64'(n_issued));
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
        finish_run();
    end
endmodule